// File: doc/BRIEF.md
# Event Capture Unit with Coherent Two-Read Readout

This block takes a snapshot of a counter pair when an external event occurs. A prescale count and a free-running count come in from counters outside the block. Two event lines also come in from outside, and a select input decides which of the two lines triggers a snapshot. Each event line passes through a synchronizer and an edge detector. When a rising edge is seen on the selected line, the block stores both counter values in a pair of capture registers.

Software reads the snapshot in two steps, and the free-running value must be read first. That first read also copies the captured prescale value into a shadow register. The second read returns the shadow, not the live capture register. A new event that lands between the two reads therefore cannot tear the pair apart. A new event that lands before the first read simply replaces the earlier snapshot.

Top module: `evtcap_top`

## Requirements
- R1: After reset, the captured pair, the shadow register and both read-data outputs are zero. A read pair issued straight after reset returns zero for both values.
- R2: Suppose an event line rises between two clock edges. The capture registers then take the values present on `preCount` and `frcCount` at the third rising clock edge after the line rises.
- R3: A rising edge on the event line that is not selected leaves both capture registers unchanged.
- R4: When `evtSel` is 0, line `evtIn[0]` triggers a capture. When `evtSel` is 1, line `evtIn[1]` triggers a capture.
- R5: Each rising edge gives exactly one capture. While the selected line stays high, changes on the counters are not captured.
- R6: A one-cycle pulse on `rdFrcStb` has two effects at the next clock edge. `frcRdData` takes the captured free-running value, and the shadow register takes the captured prescale value.
- R7: A one-cycle pulse on `rdPreStb` makes `preRdData` take the shadow register value at the next clock edge.
- R8: Suppose a capture lands after a free-running read but before the prescale read. The prescale read still returns the value that belongs to the first read. The next free-running read returns the new capture.
- R9: A second capture that occurs before any read replaces the earlier captured pair.
- R10: A capture and a free-running read may take effect on the same clock edge. In that case the read, and the prescale read that follows it, return the pair that was held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | NUM_EVT (2) | Event lines, asynchronous to clk |
| evtSel | input | 1 | Chooses the triggering event line |
| preCount | input | CNT_W (32) | Current prescale count |
| frcCount | input | CNT_W (32) | Current free-running count |
| rdFrcStb | input | 1 | Read strobe for the captured free-running value; also loads the shadow register |
| rdPreStb | input | 1 | Read strobe for the shadowed prescale value |
| frcRdData | output | CNT_W (32) | Registered captured free-running value |
| preRdData | output | CNT_W (32) | Registered shadowed prescale value |

## Verification
A vector table sends pulses on each line under each select setting. Captured and ignored cases alternate, so a missing capture can be told apart from a capture on the wrong line. A latency test changes the counters on the edges just before and just after the capture edge, which pins the capture to the third edge exactly. Directed tests cover four more cases: a long-held event line, back-to-back captures with no read, a capture between the two reads, and a capture on the same edge as the first read. Each of these separates shadow-based readout from a direct read of the capture registers.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;
  typedef struct packed {
    logic capture;
    logic loadShadow;
    logic readPre;
  } capStrobes_t;
endpackage

// File: rtl/evtcap_sync.sv
module evtcap_sync #(
  parameter int NUM_EVT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic [NUM_EVT-1:0] evtRise
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevLvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '0;
        prevLvl <= 1'b0;
      end else begin
        chain   <= {chain[LAST-1:0], evtIn[gi]};
        prevLvl <= chain[LAST];
      end
    end

    assign evtRise[gi] = chain[LAST] & ~prevLvl;

    // one detected edge is a single-cycle pulse (R5)
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
      evtRise[gi] |=> !evtRise[gi]);
  end
endmodule

// File: rtl/evtcap_ctrl.sv
module evtcap_ctrl
  import evtcap_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtRise,
  input  logic [SEL_W-1:0]   evtSel,
  input  logic               rdFrcStb,
  input  logic               rdPreStb,
  output capStrobes_t        strobes
);
  always_comb begin
    strobes            = '0;
    strobes.capture    = evtRise[evtSel];
    strobes.loadShadow = rdFrcStb;
    strobes.readPre    = rdPreStb;
  end

  // an edge on the unselected line alone never captures (R3)
  assert_unselected_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtSel == SEL_W'(0) && !evtRise[0]) |-> !strobes.capture);
endmodule

// File: rtl/evtcap_datapath.sv
module evtcap_datapath
  import evtcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobes_t      strobes,
  input  logic [CNT_W-1:0] preCount,
  input  logic [CNT_W-1:0] frcCount,
  output logic [CNT_W-1:0] frcRdData,
  output logic [CNT_W-1:0] preRdData
);
  logic [CNT_W-1:0] capPre, capFrc, shadowPre;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPre <= '0;
      capFrc <= '0;
    end else if (strobes.capture) begin
      capPre <= preCount;
      capFrc <= frcCount;
    end
  end

  // the read sees the pair held before this edge, even when a capture lands on it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPre <= '0;
      frcRdData <= '0;
    end else if (strobes.loadShadow) begin
      shadowPre <= capPre;
      frcRdData <= capFrc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preRdData <= '0;
    else if (strobes.readPre) preRdData <= shadowPre;
  end

  assert_capture_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (capPre == $past(preCount) && capFrc == $past(frcCount)));

  assert_no_capture_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(capPre) && $stable(capFrc)));

  assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadShadow |=> (shadowPre == $past(capPre) && frcRdData == $past(capFrc)));

  assert_pre_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readPre |=> preRdData == $past(shadowPre));

  assert_shadow_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadShadow |=> $stable(shadowPre));
endmodule

// File: rtl/evtcap_top.sv
module evtcap_top
  import evtcap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NUM_EVT     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [SEL_W-1:0]   evtSel,
  input  logic [CNT_W-1:0]   preCount,
  input  logic [CNT_W-1:0]   frcCount,
  input  logic               rdFrcStb,
  input  logic               rdPreStb,
  output logic [CNT_W-1:0]   frcRdData,
  output logic [CNT_W-1:0]   preRdData
);
  logic [NUM_EVT-1:0] evtRise;
  capStrobes_t        strobes;

  evtcap_sync #(.NUM_EVT(NUM_EVT), .SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .evtRise(evtRise));

  evtcap_ctrl #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .evtRise(evtRise), .evtSel(evtSel),
    .rdFrcStb(rdFrcStb), .rdPreStb(rdPreStb), .strobes(strobes));

  evtcap_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .preCount(preCount), .frcCount(frcCount),
    .frcRdData(frcRdData), .preRdData(preRdData));
endmodule

// File: tb/evtcap_top_test.sv
`timescale 1ns/1ps
module evtcap_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  evtIn = 2'b00;
  logic        evtSel = 1'b0;
  logic [31:0] preCount = '0, frcCount = '0;
  logic        rdFrcStb = 1'b0, rdPreStb = 1'b0;
  logic [31:0] frcRdData, preRdData;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] expPre = '0, expFrc = '0;

  always #4 clk = ~clk;

  evtcap_top uut (.clk(clk), .rstN(rstN), .evtIn(evtIn), .evtSel(evtSel),
    .preCount(preCount), .frcCount(frcCount), .rdFrcStb(rdFrcStb),
    .rdPreStb(rdPreStb), .frcRdData(frcRdData), .preRdData(preRdData));

  // {sel, line, pre, frc}
  localparam logic [65:0] VEC [6] = '{
    {1'b0, 1'b0, 32'h0000_0011, 32'hA000_0001},
    {1'b0, 1'b1, 32'h0000_0022, 32'hA000_0002},
    {1'b1, 1'b1, 32'h0000_0033, 32'hA000_0003},
    {1'b1, 1'b0, 32'h0000_0044, 32'hA000_0004},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(int line);
    evtIn[line] = 1'b1; step(4);
    evtIn[line] = 1'b0; step(3);
  endtask

  task automatic readFrc();
    rdFrcStb = 1'b1; step(); rdFrcStb = 1'b0;
  endtask

  task automatic readPre();
    rdPreStb = 1'b1; step(); rdPreStb = 1'b0;
  endtask

  task automatic readPair(string tag, logic [31:0] ePre, logic [31:0] eFrc);
    readFrc(); check({tag, " frc"}, frcRdData, eFrc);
    readPre(); check({tag, " pre"}, preRdData, ePre);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset state
    check("R1 frcRdData in reset", frcRdData, 32'h0);
    check("R1 preRdData in reset", preRdData, 32'h0);
    rstN = 1'b1; step(2);
    readPair("R1 after reset", 32'h0, 32'h0);

    // R3 R4: vector table
    foreach (VEC[i]) begin
      evtSel   = VEC[i][65];
      preCount = VEC[i][63:32];
      frcCount = VEC[i][31:0];
      step();
      pulse(int'(VEC[i][64]));
      if (VEC[i][64] == VEC[i][65]) begin
        expPre = VEC[i][63:32]; expFrc = VEC[i][31:0];
      end
      readPair($sformatf("R4/R3 vec%0d", i), expPre, expFrc);
    end

    // R2: capture latency of three edges
    evtSel = 1'b0; preCount = 32'h100; frcCount = 32'h200;
    evtIn[0] = 1'b1; step(2);
    preCount = 32'h101; frcCount = 32'h201; step();
    preCount = 32'h102; frcCount = 32'h202; step(2);
    evtIn[0] = 1'b0; step(3);
    readPair("R2 latency", 32'h101, 32'h201);

    // R5: held line captures once
    preCount = 32'h300; frcCount = 32'h400;
    evtIn[0] = 1'b1; step(5);
    preCount = 32'h301; frcCount = 32'h401; step(6);
    evtIn[0] = 1'b0; step(3);
    readPair("R5 held line", 32'h300, 32'h400);

    // R9: second capture before reads overwrites
    preCount = 32'h500; frcCount = 32'h600; pulse(0);
    preCount = 32'h501; frcCount = 32'h601; pulse(0);
    readPair("R9 overwrite", 32'h501, 32'h601);

    // R6 R8: capture between frc read and pre read
    preCount = 32'h700; frcCount = 32'h800; pulse(0);
    readFrc(); check("R6 frc read", frcRdData, 32'h800);
    preCount = 32'h701; frcCount = 32'h801; pulse(0);
    readPre(); check("R8 pre from shadow", preRdData, 32'h700);
    readPair("R8 next pair", 32'h701, 32'h801);

    // R10: capture on the same edge as the frc read
    preCount = 32'h900; frcCount = 32'hA00;
    evtIn[0] = 1'b1; step(2);
    rdFrcStb = 1'b1; step(); rdFrcStb = 1'b0;
    check("R10 frc same edge", frcRdData, 32'h701 + 32'h100);
    readPre(); check("R10 pre same edge", preRdData, 32'h701);
    evtIn[0] = 1'b0; step(3);
    readPair("R10 following pair", 32'h900, 32'hA00);

    // R7: repeated pre read returns shadow again
    readPre(); check("R7 repeat pre read", preRdData, 32'h900);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule